// File: doc/BRIEF.md
# Hash Engine Control Register Block

This block is the register front end of a hash accelerator. Software programs the source address, the destination address, the key buffer address and the source length over a simple word bus. Each register keeps only the bits that its alignment and range allow. Writing the command register decodes a two-level algorithm selection. The upper level picks an algorithm family, and a second field picks the variant inside the 512-bit family. A valid selection sends a one-cycle start pulse to the hash datapath, and the decoded algorithm, mode and scatter-gather selection are presented on output ports.

While an operation is in flight the block is busy, and further command writes are dropped. When the datapath signals completion, a completion flag is set in the status register whether or not interrupts are enabled. The interrupt line is raised only if the command that launched the operation had its interrupt-enable bit set. Software clears the flag, and with it the interrupt, by writing one to the flag bit. Bus reads return data one cycle after the request.

Top module: `hash_ctrl_regs`

## Requirements
- R1: After reset every register reads zero, and `start` and `irq` are low.
- R2: Address and length registers apply these write masks:
  - source address at byte offset 0x20 keeps bits 30:0;
  - destination address at 0x24 keeps bits 30:3, giving 8-byte alignment;
  - key buffer address at 0x28 keeps bits 30:3;
  - source length at 0x2C keeps bits 27:0.
- R3: The command register at offset 0x30 stores the written word ANDed with 0x00147FFF, and reads it back.
- R4: Command bits 6:4 select the family: 000 MD5, 010 SHA-1, 100 SHA-224, 101 SHA-256, 011 the 512-bit family. Bits 12:10 must be 000 outside the 512-bit family. Inside it they select 000 SHA-512, 001 SHA-384 or 010 SHA-512/256. The `alg` output is coded 0 MD5, 1 SHA-1, 2 SHA-224, 3 SHA-256, 4 SHA-512, 5 SHA-384, 6 SHA-512/256, and 7 for an invalid selection.
- R5: A command with an invalid selection is stored but produces no start pulse.
- R6: A valid command write accepted on a clock edge makes `start` high for exactly the following cycle.
- R7: While an operation is in flight, meaning between a start and the next `done`, command writes are ignored. No start is produced and the stored command is unchanged.
- R8: `done` during an operation sets the completion flag, status bit 9, regardless of interrupt enable. `done` while idle has no effect.
- R9: `irq` rises on completion only when command bit 9 was set in the launching command.
- R10: Writing status with bit 9 set clears the flag and lowers `irq`. Writing status with bit 9 clear leaves both unchanged.
- R11: Reads at byte offsets other than 0x1C, 0x20, 0x24, 0x28, 0x2C and 0x30 return zero, and writes there change no register.
- R12: `mode` reflects stored command bits 8:7 and `sg_en` reflects stored command bit 18.
- R13: `rdata` holds the value of the addressed register one cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| done | input | 1 | Completion from the hash datapath |
| start | output | 1 | One-cycle launch pulse to the datapath |
| alg | output | 3 | Decoded algorithm code |
| mode | output | 2 | Stored command mode field |
| sg_en | output | 1 | Stored scatter-gather enable |
| irq | output | 1 | Completion interrupt |

## Verification
A command write accepted on one edge produces `start`, the new `alg` value and the mode outputs after that same edge. `start` drops after the next edge. Completion status and `irq` follow the edge that samples `done`, and read data follows the edge that samples `rd_en`. The bench drives every input at a falling edge and samples at the next falling edge. Each result is therefore read exactly one register stage after its cause, and the one-cycle width of `start` is confirmed one falling edge later.

// File: rtl/hash_regs_pkg.sv
package hash_regs_pkg;
  localparam int WORD_W   = 32;
  localparam int STAT_OFF = 'h1C;
  localparam int SRC_OFF  = 'h20;
  localparam int DST_OFF  = 'h24;
  localparam int KEY_OFF  = 'h28;
  localparam int LEN_OFF  = 'h2C;
  localparam int CMD_OFF  = 'h30;
  localparam int NSLOT    = 4;
  localparam int FLAG_BIT = 9;
  localparam int IEN_BIT  = 9;
  localparam int SG_BIT   = 18;

  typedef enum logic [2:0] {
    ALG_MD5 = 3'd0, ALG_SHA1 = 3'd1, ALG_SHA224 = 3'd2, ALG_SHA256 = 3'd3,
    ALG_SHA512 = 3'd4, ALG_SHA384 = 3'd5, ALG_SHA512_256 = 3'd6, ALG_NONE = 3'd7
  } alg_e;

  // Two-level decode: family in bits 6:4, 512-bit variant in bits 12:10.
  function automatic alg_e pick_alg(input logic [WORD_W-1:0] c);
    logic [2:0] fam;
    logic [2:0] sub;
    fam = c[6:4];
    sub = c[12:10];
    if (fam == 3'b011) begin
      case (sub)
        3'b000:  return ALG_SHA512;
        3'b001:  return ALG_SHA384;
        3'b010:  return ALG_SHA512_256;
        default: return ALG_NONE;
      endcase
    end
    if (sub != 3'b000) return ALG_NONE;
    case (fam)
      3'b000:  return ALG_MD5;
      3'b010:  return ALG_SHA1;
      3'b100:  return ALG_SHA224;
      3'b101:  return ALG_SHA256;
      default: return ALG_NONE;
    endcase
  endfunction

  function automatic int slot_off(input int i);
    case (i)
      0:       return SRC_OFF;
      1:       return DST_OFF;
      2:       return KEY_OFF;
      default: return LEN_OFF;
    endcase
  endfunction
endpackage

// File: rtl/hash_cmd_decode.sv
module hash_cmd_decode
  import hash_regs_pkg::*;
(
  input  logic [WORD_W-1:0] cmd,
  output logic [2:0]        alg,
  output logic              alg_ok,
  output logic [1:0]        mode,
  output logic              sg_en,
  output logic              irq_en
);
  alg_e sel;
  assign sel    = pick_alg(cmd);
  assign alg    = sel;
  assign alg_ok = (sel != ALG_NONE);
  assign mode   = cmd[8:7];
  assign sg_en  = cmd[SG_BIT];
  assign irq_en = cmd[IEN_BIT];
endmodule

// File: rtl/hash_reg_file.sv
module hash_reg_file
  import hash_regs_pkg::*;
#(
  parameter int              ADDR_W   = 12,
  parameter logic [WORD_W-1:0] SRC_MASK = 32'h7FFF_FFFF,
  parameter logic [WORD_W-1:0] DST_MASK = 32'h7FFF_FFF8,
  parameter logic [WORD_W-1:0] KEY_MASK = 32'h7FFF_FFF8,
  parameter logic [WORD_W-1:0] LEN_MASK = 32'h0FFF_FFFF,
  parameter logic [WORD_W-1:0] CMD_MASK = 32'h0014_7FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              busy,
  input  logic              flag,
  output logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] cmd_q,
  output logic              cmd_wr_evt
);
  function automatic logic [WORD_W-1:0] slot_mask(input int i);
    case (i)
      0:       return SRC_MASK;
      1:       return DST_MASK;
      2:       return KEY_MASK;
      default: return LEN_MASK;
    endcase
  endfunction

  logic [WORD_W-1:0] slot_vals [NSLOT];
  logic [WORD_W-1:0] rd_mux;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [WORD_W-1:0] val_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        val_q <= '0;
      else if (wr_en && addr == ADDR_W'(slot_off(g)))
        val_q <= wdata & slot_mask(g);
    end
    assign slot_vals[g] = val_q;
  end

  assign cmd_wr_evt = wr_en && (addr == ADDR_W'(CMD_OFF)) && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n)          cmd_q <= '0;
    else if (cmd_wr_evt) cmd_q <= wdata & CMD_MASK;
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NSLOT; i++)
      if (addr == ADDR_W'(slot_off(i))) rd_mux = slot_vals[i];
    if (addr == ADDR_W'(CMD_OFF))  rd_mux = cmd_q;
    if (addr == ADDR_W'(STAT_OFF)) rd_mux = WORD_W'(flag) << FLAG_BIT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/hash_done_ctrl.sv
module hash_done_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic irq_req,
  input  logic done,
  input  logic clr_req,
  output logic start,
  output logic busy,
  output logic flag,
  output logic irq,
  output logic done_acc
);
  logic ien_q;

  assign done_acc = done && busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start <= 1'b0;
      busy  <= 1'b0;
      ien_q <= 1'b0;
      flag  <= 1'b0;
      irq   <= 1'b0;
    end else begin
      start <= launch;
      if (launch) begin
        busy  <= 1'b1;
        ien_q <= irq_req;
      end else if (done_acc) begin
        busy  <= 1'b0;
      end
      if (done_acc)     flag <= 1'b1;
      else if (clr_req) flag <= 1'b0;
      if (done_acc && ien_q) irq <= 1'b1;
      else if (clr_req)      irq <= 1'b0;
    end
  end
endmodule

// File: rtl/hash_ctrl_regs.sv
module hash_ctrl_regs
  import hash_regs_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              done,
  output logic              start,
  output logic [2:0]        alg,
  output logic [1:0]        mode,
  output logic              sg_en,
  output logic              irq
);
  logic [WORD_W-1:0] cmd_q;
  logic cmd_wr_evt, launch, clr_req, busy, flag, done_acc;
  logic new_ok, new_ien, cur_ok, cur_ien, new_sg;
  logic [2:0] new_alg;
  logic [1:0] new_mode;

  hash_reg_file #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .busy(busy), .flag(flag), .rdata(rdata), .cmd_q(cmd_q),
    .cmd_wr_evt(cmd_wr_evt)
  );

  // Decode of the incoming word decides the launch.
  hash_cmd_decode u_dec_new (
    .cmd(wdata), .alg(new_alg), .alg_ok(new_ok), .mode(new_mode),
    .sg_en(new_sg), .irq_en(new_ien)
  );

  // Decode of the stored word drives the selection ports.
  hash_cmd_decode u_dec_cur (
    .cmd(cmd_q), .alg(alg), .alg_ok(cur_ok), .mode(mode),
    .sg_en(sg_en), .irq_en(cur_ien)
  );

  assign launch  = cmd_wr_evt && new_ok;
  assign clr_req = wr_en && (addr == ADDR_W'(STAT_OFF)) && wdata[FLAG_BIT];

  hash_done_ctrl u_done (
    .clk(clk), .rst_n(rst_n), .launch(launch), .irq_req(new_ien),
    .done(done), .clr_req(clr_req), .start(start), .busy(busy),
    .flag(flag), .irq(irq), .done_acc(done_acc)
  );
endmodule

// File: rtl/hash_ctrl_regs_chk.sv
module hash_ctrl_regs_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic launch,
  input logic busy,
  input logic flag,
  input logic irq,
  input logic clr_req,
  input logic done_acc
);
  // R6
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);
  // R6
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> $past(launch));
  // R7
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !launch);
  // R9
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);
  // R8
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_acc |=> flag);
  // R10
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !done_acc) |=> (!flag && !irq));
endmodule

bind hash_ctrl_regs hash_ctrl_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .launch(launch), .busy(busy),
  .flag(flag), .irq(irq), .clr_req(clr_req), .done_acc(done_acc)
);

// File: tb/test_hash_ctrl_regs.sv
module test_hash_ctrl_regs;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam logic [31:0] CMD_KEEP = 32'h0014_7FFF;

  typedef struct packed {
    logic [31:0] cmd;
    logic        go;
    logic [2:0]  alg;
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{32'h0000_0000, 1'b1, 3'd0},
    '{32'h0000_0020, 1'b1, 3'd1},
    '{32'h0000_0040, 1'b1, 3'd2},
    '{32'h0000_0050, 1'b1, 3'd3},
    '{32'h0000_0030, 1'b1, 3'd4},
    '{32'h0000_0430, 1'b1, 3'd5},
    '{32'h0000_0830, 1'b1, 3'd6},
    '{32'h0000_0C30, 1'b0, 3'd7},
    '{32'h0000_0010, 1'b0, 3'd7},
    '{32'h0000_0060, 1'b0, 3'd7},
    '{32'h0000_0420, 1'b0, 3'd7},
    '{32'h0004_01D0, 1'b1, 3'd3},
    '{32'hFFF8_0050, 1'b1, 3'd3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, done = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic start, sg_en, irq;
  logic [2:0] alg;
  logic [1:0] mode;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hash_ctrl_regs #(.ADDR_W(AW)) i_hash_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .done(done), .start(start), .alg(alg),
    .mode(mode), .sg_en(sg_en), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // R13: data sampled one cycle after the request
  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 start", 32'(start), 0);
    check("R1 irq", 32'(irq), 0);
    for (int a = 'h1C; a <= 'h30; a += 4) begin
      rd(a, v);
      check("R1 R13 reset read", v, 0);
    end

    // R4 R5 R3 R6 table walk
    for (int i = 0; i < 13; i++) begin
      wr('h30, VECS[i].cmd);
      check("R6 R5 start", 32'(start), 32'(VECS[i].go));
      check("R4 alg", 32'(alg), 32'(VECS[i].alg));
      @(negedge clk);
      check("R6 one cycle", 32'(start), 0);
      rd('h30, v);
      check("R3 cmd readback", v, VECS[i].cmd & CMD_KEEP);
      if (i == 11) begin
        check("R12 mode", 32'(mode), 3);
        check("R12 sg", 32'(sg_en), 1);
      end
      if (VECS[i].go) pulse_done();
      check("R9 no irq when disabled", 32'(irq), 0);
    end
    wr('h1C, 32'h200);

    // R2 address masks
    wr('h20, 32'hFFFF_FFFF); rd('h20, v); check("R2 src", v, 32'h7FFF_FFFF);
    wr('h24, 32'hFFFF_FFFF); rd('h24, v); check("R2 dst", v, 32'h7FFF_FFF8);
    wr('h28, 32'hFFFF_FFFF); rd('h28, v); check("R2 key", v, 32'h7FFF_FFF8);
    wr('h2C, 32'hFFFF_FFFF); rd('h2C, v); check("R2 len", v, 32'h0FFF_FFFF);

    // R11 outside window
    wr('h34, 32'hFFFF_FFFF); rd('h34, v); check("R11 read zero", v, 0);
    wr('h22, 32'h1234_5678); rd('h20, v); check("R11 write ignored", v, 32'h7FFF_FFFF);
    rd('h00, v); check("R11 read low", v, 0);

    // R7 busy drops command
    wr('h30, 32'h50);
    check("R7 first start", 32'(start), 1);
    wr('h30, 32'h20);
    check("R7 no start busy", 32'(start), 0);
    rd('h30, v); check("R7 cmd kept", v, 32'h50);
    // R8 flag set without irq enable
    pulse_done();
    check("R8 irq low", 32'(irq), 0);
    rd('h1C, v); check("R8 flag", v, 32'h200);
    // R10 write zero keeps flag, write one clears
    wr('h1C, 32'h0); rd('h1C, v); check("R10 write0 keeps", v, 32'h200);
    wr('h1C, 32'h200); rd('h1C, v); check("R10 clear", v, 0);
    // R8 done while idle
    pulse_done(); rd('h1C, v); check("R8 idle done", v, 0);

    // R9 irq with enable
    wr('h30, 32'h250);
    check("R9 start", 32'(start), 1);
    pulse_done();
    check("R9 irq high", 32'(irq), 1);
    rd('h1C, v); check("R9 flag", v, 32'h200);
    wr('h1C, 32'h200);
    check("R10 irq cleared", 32'(irq), 0);
    rd('h1C, v); check("R10 flag cleared", v, 0);

    finish_run();
  end
endmodule